// File: doc/BRIEF.md
# Enable Qualification and Power-State Controller

This block turns a noisy, asynchronous hardware enable pin into a clean run decision for a step-down converter. The pin goes through a synchronizer. Its level is then accepted only after it has held its new value for a programmable number of millisecond ticks. The accepted level is combined with a gating bit and a sleep override to choose one of three conditions: running, low-quiescent standby, or forced sleep.

The block also handles shutdown faults (over-temperature or output short). A fault stops the converter at once. When the fault clears, a rearm bit decides what happens next. With rearm set, the converter restarts through a fast power-up sequence and keeps the programmed settings. With rearm clear, the block asks for a reload of the register defaults and holds the converter off until the enable is cycled. A software-initiated reset strobe raises the same reload request. A sticky status flag records that a reload took place.

All pins are plain control and status signals: no data stream crosses the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pwr_enable_ctl`

## Requirements
- R1: After reset, `conv_run`, `seq_start` and `cfg_reload_req` are 0 and `reload_flag` is 1.
- R2: The enable pin is active high. A change of its synchronized level is accepted only after that level has been present for a number of `tick_1ms` pulses set by `dbn_sel`. For codes 0 (00) and 1 (01) this is 2 pulses. `conv_run` follows the accepted level two clock cycles after the qualifying tick.
- R3: `dbn_sel` code 2 (10) requires 3 ticks and code 3 (11) requires 4 ticks before the new pin level is accepted.
- R4: A return of the pin to the accepted level before the window completes discards the ticks already counted.
- R5: While `pin_gate` is 0 the pin has no effect and `conv_run` is 0 one cycle later. Setting `pin_gate` to 1 with an accepted high level starts the converter one cycle later.
- R6: While `sleep_force` is 1, `conv_run` is 0 one cycle later, whatever the pin does. With `sleep_force` at 0 and the enable low, the block sits in standby.
- R7: `seq_start` is a one-cycle pulse. It is asserted in the first cycle of every entry into the running state, together with the rise of `conv_run`.
- R8: A high `therm_fault` or `short_fault` drops `conv_run` on the next cycle.
- R9: With `rearm` at 1, the cycle after a fault clears (enable still qualified, no sleep override) shows `conv_run` at 1 and a `seq_start` pulse, with no `cfg_reload_req`.
- R10: With `rearm` at 0, the cycle after a fault clears shows a one-cycle `cfg_reload_req` pulse. `conv_run` stays 0 until the qualified enable has gone low and come back high.
- R11: A one-cycle `force_reset_wr` strobe yields a one-cycle `cfg_reload_req` pulse on the next cycle.
- R12: `reload_flag` becomes 1 together with every `cfg_reload_req` pulse. It is cleared by `reload_flag_clr` and holds otherwise. If both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Raw hardware enable pin, asynchronous |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| dbn_sel | input | 2 | Debounce window code |
| pin_gate | input | 1 | 1 lets the pin control the converter |
| sleep_force | input | 1 | 1 forces sleep |
| therm_fault | input | 1 | Thermal shutdown active |
| short_fault | input | 1 | Short-circuit protection active |
| rearm | input | 1 | 1 restarts after a fault with settings kept |
| force_reset_wr | input | 1 | Strobe: software wrote 1 to the force-reset bit |
| reload_flag_clr | input | 1 | Strobe: software wrote 0 to the reset-status bit |
| conv_run | output | 1 | Converter enabled |
| seq_start | output | 1 | Fast power-up sequence start pulse |
| cfg_reload_req | output | 1 | Request to reload register defaults |
| reload_flag | output | 1 | Sticky reset-status indicator |

## Verification
The debounce path is driven with pin steps under every window code. Each step gets one tick fewer than the window, then the last tick. This tells a correct window apart from one that is a tick short or long. Glitches that return to the accepted level before the window ends show whether partial counts are discarded. Random mixes of pin level, gate, sleep and code check the run decision against a bench function of those inputs. Directed fault sequences with rearm set and clear separate the restart-with-settings path from the reload-and-lock path. The same-cycle set/clear of the status flag confirms its priority.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  typedef enum logic [2:0] {
    PS_STANDBY = 3'd0,
    PS_SLEEP   = 3'd1,
    PS_RUN     = 3'd2,
    PS_FAULT   = 3'd3,
    PS_LOCKED  = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d_async;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/level_debounce.sv
module level_debounce #(
  parameter int CODE_W = 2,
  parameter int CNT_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_s,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              lvl
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] need;

  // Window of N..N+1 ms takes N+1 ticks; code 0 behaves like code 1.
  always_comb begin
    need = (code == '0) ? CNT_W'(2) : CNT_W'(code) + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (pin_s == lvl) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt + CNT_W'(1) >= need) begin
        lvl <= pin_s;
        cnt <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R2
  lvl_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> $past(tick));

  // R4
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_s == lvl) |=> (lvl == $past(lvl)));
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic sleep_force,
  input  logic fault,
  input  logic rearm,
  output logic run,
  output logic seq_start,
  output logic fault_reload
);
  pwr_state_e st, st_nx;

  always_comb begin
    st_nx        = st;
    fault_reload = 1'b0;
    unique case (st)
      PS_STANDBY, PS_SLEEP: begin
        if (sleep_force)          st_nx = PS_SLEEP;
        else if (en_q && !fault)  st_nx = PS_RUN;
        else                      st_nx = PS_STANDBY;
      end
      PS_RUN: begin
        if (fault)             st_nx = PS_FAULT;
        else if (sleep_force)  st_nx = PS_SLEEP;
        else if (!en_q)        st_nx = PS_STANDBY;
      end
      PS_FAULT: begin
        if (!fault) begin
          if (!rearm) begin
            fault_reload = 1'b1;
            st_nx        = PS_LOCKED;
          end else if (en_q && !sleep_force) begin
            st_nx = PS_RUN;
          end else begin
            st_nx = sleep_force ? PS_SLEEP : PS_STANDBY;
          end
        end
      end
      PS_LOCKED: begin
        if (!en_q) st_nx = sleep_force ? PS_SLEEP : PS_STANDBY;
      end
      default: st_nx = PS_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_STANDBY;
      seq_start <= 1'b0;
    end else begin
      st        <= st_nx;
      seq_start <= (st_nx == PS_RUN) && (st != PS_RUN);
    end
  end

  assign run = (st == PS_RUN);

  // R7
  seq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

  // R7
  seq_with_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> run);

  // R8
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !run);

  // R6
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_force |=> !run);

  // R10
  lock_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_reload |=> !run);
endmodule

// File: rtl/pwr_enable_ctl.sv
module pwr_enable_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin,
  input  logic              tick_1ms,
  input  logic [CODE_W-1:0] dbn_sel,
  input  logic              pin_gate,
  input  logic              sleep_force,
  input  logic              therm_fault,
  input  logic              short_fault,
  input  logic              rearm,
  input  logic              force_reset_wr,
  input  logic              reload_flag_clr,
  output logic              conv_run,
  output logic              seq_start,
  output logic              cfg_reload_req,
  output logic              reload_flag
);
  logic pin_s, pin_lvl, fault_reload, reload_now;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(en_pin), .d_sync(pin_s)
  );

  level_debounce #(.CODE_W(CODE_W)) u_dbn (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .tick(tick_1ms),
    .code(dbn_sel), .lvl(pin_lvl)
  );

  pwr_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_q(pin_lvl & pin_gate),
    .sleep_force(sleep_force), .fault(therm_fault | short_fault),
    .rearm(rearm), .run(conv_run), .seq_start(seq_start),
    .fault_reload(fault_reload)
  );

  assign reload_now = fault_reload | force_reset_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_reload_req <= 1'b0;
      reload_flag    <= 1'b1;
    end else begin
      cfg_reload_req <= reload_now;
      if (reload_now)           reload_flag <= 1'b1;
      else if (reload_flag_clr) reload_flag <= 1'b0;
    end
  end

  // R11
  force_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_reset_wr |=> cfg_reload_req);

  // R12
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reload_req |-> reload_flag);

  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_gate |=> !conv_run);
endmodule

// File: tb/tb_pwr_enable_ctl.sv
module tb_pwr_enable_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 0, tick_1ms = 0, pin_gate = 0, sleep_force = 0;
  logic therm_fault = 0, short_fault = 0, rearm = 0;
  logic force_reset_wr = 0, reload_flag_clr = 0;
  logic [1:0] dbn_sel = 2'd0;
  logic conv_run, seq_start, cfg_reload_req, reload_flag;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_enable_ctl dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .tick_1ms(tick_1ms),
    .dbn_sel(dbn_sel), .pin_gate(pin_gate), .sleep_force(sleep_force),
    .therm_fault(therm_fault), .short_fault(short_fault), .rearm(rearm),
    .force_reset_wr(force_reset_wr), .reload_flag_clr(reload_flag_clr),
    .conv_run(conv_run), .seq_start(seq_start),
    .cfg_reload_req(cfg_reload_req), .reload_flag(reload_flag)
  );

  function automatic int ticks_for(input logic [1:0] c);
    return (c == 2'd0) ? 2 : int'(c) + 1;
  endfunction

  function automatic bit exp_run(input bit lvl, input bit g, input bit s);
    return lvl & g & ~s;
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_once();
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_once();
      @(negedge clk);
    end
  endtask

  task automatic set_pin(input bit v);
    en_pin = v;
    cyc_n(3);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    cyc_n(WATCHDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish at cycle %0d", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0001));
    cyc_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(conv_run, 0, "R1 run");
    chk(seq_start, 0, "R1 seq");
    chk(cfg_reload_req, 0, "R1 req");
    chk(reload_flag, 1, "R1 flag");

    // R12 software clear
    reload_flag_clr = 1; @(negedge clk); reload_flag_clr = 0;
    chk(reload_flag, 0, "R12 clear");

    // R5 gate low: pin ignored
    dbn_sel = 2'd3; set_pin(1); ticks(4); cyc_n(1); acc = 1;
    chk(conv_run, 0, "R5 gated off");
    pin_gate = 1; @(negedge clk);
    chk(conv_run, 1, "R5 gate on");
    chk(seq_start, 1, "R7 pulse");
    @(negedge clk);
    chk(seq_start, 0, "R7 single");

    // R2 codes 00 and 01: 2 ticks
    dbn_sel = 2'd0; set_pin(0); ticks(1); cyc_n(1);
    chk(conv_run, 1, "R2 c0 early");
    ticks(1); cyc_n(1);
    chk(conv_run, 0, "R2 c0 accept");
    dbn_sel = 2'd1; set_pin(1); ticks(1); cyc_n(1);
    chk(conv_run, 0, "R2 c1 early");
    ticks(1);
    chk(conv_run, 1, "R2 c1 accept");
    chk(seq_start, 1, "R7 entry pulse");
    cyc_n(1);

    // R3 codes 10 and 11
    dbn_sel = 2'd2; set_pin(0); ticks(2); cyc_n(1);
    chk(conv_run, 1, "R3 c2 early");
    ticks(1); cyc_n(1);
    chk(conv_run, 0, "R3 c2 accept");
    dbn_sel = 2'd3; set_pin(1); ticks(3); cyc_n(1);
    chk(conv_run, 0, "R3 c3 early");
    ticks(1); cyc_n(1);
    chk(conv_run, 1, "R3 c3 accept");

    // R4 glitch restarts count
    dbn_sel = 2'd0; set_pin(0); ticks(1); set_pin(1); set_pin(0);
    ticks(1); cyc_n(1);
    chk(conv_run, 1, "R4 glitch discarded");
    ticks(1); cyc_n(1);
    chk(conv_run, 0, "R4 accept");
    set_pin(1); ticks(2); cyc_n(1);
    chk(conv_run, 1, "R4 back on");

    // R6 sleep override
    sleep_force = 1; @(negedge clk);
    chk(conv_run, 0, "R6 sleep");
    set_pin(0); set_pin(1); ticks(2); cyc_n(1);
    chk(conv_run, 0, "R6 pin ignored");
    sleep_force = 0; @(negedge clk);
    chk(conv_run, 1, "R6 wake");
    chk(seq_start, 1, "R7 wake pulse");
    cyc_n(1);

    // R8 + R9 fault with rearm
    rearm = 1; therm_fault = 1; @(negedge clk);
    chk(conv_run, 0, "R8 fault stop");
    cyc_n(3);
    therm_fault = 0; @(negedge clk);
    chk(conv_run, 1, "R9 restart");
    chk(seq_start, 1, "R9 seq pulse");
    chk(cfg_reload_req, 0, "R9 no reload");
    cyc_n(1);

    // R10 fault without rearm
    rearm = 0; short_fault = 1; @(negedge clk);
    chk(conv_run, 0, "R8 short stop");
    cyc_n(2);
    short_fault = 0; @(negedge clk);
    chk(cfg_reload_req, 1, "R10 reload pulse");
    chk(reload_flag, 1, "R12 set by reload");
    chk(conv_run, 0, "R10 off");
    @(negedge clk);
    chk(cfg_reload_req, 0, "R10 pulse single");
    cyc_n(5);
    chk(conv_run, 0, "R10 locked");
    set_pin(0); ticks(2); cyc_n(1);
    chk(conv_run, 0, "R10 pin low");
    set_pin(1); ticks(2); cyc_n(1);
    chk(conv_run, 1, "R10 relaunch");

    // R11 force reset, R12 clear then set-wins
    reload_flag_clr = 1; @(negedge clk); reload_flag_clr = 0;
    chk(reload_flag, 0, "R12 clear2");
    force_reset_wr = 1; @(negedge clk); force_reset_wr = 0;
    chk(cfg_reload_req, 1, "R11 request");
    @(negedge clk);
    chk(cfg_reload_req, 0, "R11 single");
    reload_flag_clr = 1; force_reset_wr = 1; @(negedge clk);
    reload_flag_clr = 0; force_reset_wr = 0;
    chk(reload_flag, 1, "R12 set wins");

    // random mix: R2 R3 R5 R6
    for (int it = 0; it < 60; it++) begin
      bit nv, ng, ns;
      logic [1:0] nc;
      int nt;
      nv = 1'($urandom); ng = 1'($urandom % 4 != 0);
      ns = 1'($urandom % 5 == 0); nc = 2'($urandom);
      nt = ticks_for(nc);
      dbn_sel = nc; pin_gate = ng; sleep_force = ns;
      set_pin(nv);
      ticks(nt - 1); cyc_n(1);
      chk(conv_run, exp_run(acc, ng, ns), "R3 random early");
      ticks(1); cyc_n(1);
      acc = nv;
      chk(conv_run, exp_run(acc, ng, ns), "R2 random accept");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule